// File: doc/BRIEF.md
# Mode-Dependent GPIO Port Controller

This block controls one 8-bit bidirectional I/O port. A bank of five byte registers sits on a simple synchronous register bus. One register sets pin direction and cannot be read back. One is the output data latch. One is a read-only view of the pin levels. One enables pull-ups, and one selects open-drain drive. From these the block produces per-pin output enable, output value and pull-up control for the pads. Register accesses finish in the cycle they are presented and never stall, so the bus has no back-pressure path. All pins are plain control signals, with no valid/ready handshake.

In the expanded operating modes (4, 5 and 6), a 4-bit address-enable count gives the low pins of the port to an external address bus. These pins drive the address no matter what their direction bits say. Every other mode behaves as single-chip: all pins follow the direction register.

Hardware standby clears the direction register and silences every pad. Software standby keeps all register state. In software standby, a standby-output-enable input decides whether the address pins keep driving the address captured on entry or float. Reads of the direction register return a fixed fill pattern (0xFF) that carries no information.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset the data, pull-up and open-drain registers read 0x00, and pad_oe and pad_pu are 0x00.
- R2: A write to the data, pull-up or open-drain register takes effect on the clock edge that samples the write strobe. A later read returns the written byte.
- R3: On a non-address pin whose direction bit is 1 and open-drain bit is 0, pad_oe is 1 and pad_do equals the data bit.
- R4: On a pin whose direction bit is 0, pad_oe is 0 and pad_pu equals the pull-up bit. pad_pu is 0 on any pin that drives, even when its pull-up bit is 1.
- R5: On an output pin whose open-drain bit is 1, pad_do is 0 and pad_oe is the inverse of the data bit.
- R6: In modes 4 to 6, with address-enable value N, pins 0 to min(N,8)-1 have pad_oe=1 and pad_do equal to addr_bus, regardless of direction. In any other mode, address-enable has no effect.
- R7: Reading the pin-state register returns the data latch bit for pins driven from the latch. Every other pin returns pad_in after a two-flop synchroniser, so a pad change appears in reads after the second clock edge.
- R8: While hw_stby is 1, pad_oe and pad_pu are 0x00, the direction register clears, and register writes are ignored.
- R9: Software standby keeps the direction register. With stby_oe=1 the address pins keep the address captured on the last edge before entry. With stby_oe=0 they have pad_oe=0.
- R10: With bus_sel low, or at an unmapped address, bus_rdata is 0x00. Writes to unmapped addresses change no register.
- R11: Registers decode at 0xFE3A direction, 0xFF0A data, 0xFFBA pin state, 0xFF41 pull-up and 0xFE48 open-drain. A write to 0xFF0B does not reach the data register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_mode | input | 3 | Operating mode; 4 to 6 are expanded |
| addr_en | input | 4 | Count of low pins given to the address bus |
| addr_bus | input | 8 | Address bits to put on claimed pins |
| hw_stby | input | 1 | Hardware standby |
| sw_stby | input | 1 | Software standby |
| stby_oe | input | 1 | Address pins keep driving in software standby |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 16 | Register address, low 16 bits |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, combinational |
| pad_in | input | 8 | Pad input levels, asynchronous |
| pad_oe | output | 8 | Per-pin output enable |
| pad_do | output | 8 | Per-pin output value |
| pad_pu | output | 8 | Per-pin pull-up enable |

## Verification
The bench samples the pin-state register one and two edges after a pad change. A design without the synchroniser, or with the wrong number of stages, returns the new level one cycle early or late. It sets address-enable above 8 and runs single-chip mode with address-enable set, which exposes a decoder that wraps, or that lets the bus claim pins outside expanded modes. It changes addr_bus during software standby with stby_oe set, so a design that passes the live address through instead of the captured one is caught. It also writes during hardware standby and checks afterwards that direction came back cleared while data kept its value.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;
  typedef enum logic [2:0] {
    SEL_NONE,
    SEL_DIR,
    SEL_DAT,
    SEL_PIN,
    SEL_PU,
    SEL_OD
  } reg_sel_e;

  localparam logic [2:0] MODE_EXP_LO = 3'd4;
  localparam logic [2:0] MODE_EXP_HI = 3'd6;

  function automatic logic is_expanded(input logic [2:0] mode);
    return (mode >= MODE_EXP_LO) && (mode <= MODE_EXP_HI);
  endfunction
endpackage

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int W      = 8,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stage_q [STAGES];

  for (genvar s = 0; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        stage_q[s] <= '0;
      end else if (s == 0) begin
        stage_q[s] <= d;
      end else begin
        stage_q[s] <= stage_q[(s == 0) ? 0 : s-1];
      end
    end
  end

  assign q = stage_q[STAGES-1];
endmodule

// File: rtl/gpio_regbank.sv
module gpio_regbank
  import gpio_port_pkg::*;
#(
  parameter int          W        = 8,
  parameter int          AW       = 16,
  parameter logic [15:0] A_DIR    = 16'hFE3A,
  parameter logic [15:0] A_DAT    = 16'hFF0A,
  parameter logic [15:0] A_PIN    = 16'hFFBA,
  parameter logic [15:0] A_PU     = 16'hFF41,
  parameter logic [15:0] A_OD     = 16'hFE48,
  parameter logic [W-1:0] DIR_FILL = '1
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          hw_stby,
  input  logic          bus_sel,
  input  logic          bus_wr,
  input  logic [AW-1:0] bus_addr,
  input  logic [W-1:0]  bus_wdata,
  output logic [W-1:0]  bus_rdata,
  input  logic [W-1:0]  pin_view,
  output logic [W-1:0]  dir_q,
  output logic [W-1:0]  dat_q,
  output logic [W-1:0]  pu_q,
  output logic [W-1:0]  od_q
);
  reg_sel_e sel;
  logic     wr_ok;

  always_comb begin
    sel = SEL_NONE;
    if      (bus_addr == AW'(A_DIR)) sel = SEL_DIR;
    else if (bus_addr == AW'(A_DAT)) sel = SEL_DAT;
    else if (bus_addr == AW'(A_PIN)) sel = SEL_PIN;
    else if (bus_addr == AW'(A_PU))  sel = SEL_PU;
    else if (bus_addr == AW'(A_OD))  sel = SEL_OD;
  end

  assign wr_ok = bus_sel && bus_wr && !hw_stby;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dir_q <= '0;
    end else if (hw_stby) begin
      dir_q <= '0;
    end else if (wr_ok && sel == SEL_DIR) begin
      dir_q <= bus_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      dat_q <= '0;
      pu_q  <= '0;
      od_q  <= '0;
    end else if (wr_ok) begin
      if (sel == SEL_DAT) dat_q <= bus_wdata;
      if (sel == SEL_PU)  pu_q  <= bus_wdata;
      if (sel == SEL_OD)  od_q  <= bus_wdata;
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_sel) begin
      case (sel)
        SEL_DIR: bus_rdata = DIR_FILL;
        SEL_DAT: bus_rdata = dat_q;
        SEL_PIN: bus_rdata = pin_view;
        SEL_PU:  bus_rdata = pu_q;
        SEL_OD:  bus_rdata = od_q;
        default: bus_rdata = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_pin_mux.sv
module gpio_pin_mux #(
  parameter int W   = 8,
  parameter int ENW = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           expanded,
  input  logic [ENW-1:0] addr_en,
  input  logic [W-1:0]   addr_bus,
  input  logic           hw_stby,
  input  logic           sw_stby,
  input  logic           stby_oe,
  input  logic [W-1:0]   dir_q,
  input  logic [W-1:0]   dat_q,
  input  logic [W-1:0]   pu_q,
  input  logic [W-1:0]   od_q,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_do,
  output logic [W-1:0]   pad_pu,
  output logic [W-1:0]   from_latch
);
  logic [W-1:0] hold_q;
  logic [W-1:0] amask;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hold_q <= '0;
    end else if (!sw_stby) begin
      hold_q <= addr_bus;
    end
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      amask[i] = expanded && (int'(addr_en) > i);
    end
  end

  for (genvar i = 0; i < W; i++) begin : g_pin
    logic oe_i, do_i, pu_i;

    always_comb begin
      oe_i = 1'b0;
      do_i = 1'b0;
      pu_i = 1'b0;
      if (hw_stby) begin
        oe_i = 1'b0;
      end else if (amask[i]) begin
        if (sw_stby) begin
          oe_i = stby_oe;
          do_i = hold_q[i];
        end else begin
          oe_i = 1'b1;
          do_i = addr_bus[i];
        end
      end else if (dir_q[i]) begin
        if (od_q[i]) begin
          oe_i = !dat_q[i];
          do_i = 1'b0;
        end else begin
          oe_i = 1'b1;
          do_i = dat_q[i];
        end
      end else begin
        pu_i = pu_q[i];
      end
    end

    assign pad_oe[i]     = oe_i;
    assign pad_do[i]     = do_i;
    assign pad_pu[i]     = pu_i;
    assign from_latch[i] = !amask[i] && dir_q[i];
  end
endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int W       = 8,
  parameter int ENW     = 4,
  parameter int AW      = 16,
  parameter int SYNC_ST = 2
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic [2:0]     op_mode,
  input  logic [ENW-1:0] addr_en,
  input  logic [W-1:0]   addr_bus,
  input  logic           hw_stby,
  input  logic           sw_stby,
  input  logic           stby_oe,
  input  logic           bus_sel,
  input  logic           bus_wr,
  input  logic [AW-1:0]  bus_addr,
  input  logic [W-1:0]   bus_wdata,
  output logic [W-1:0]   bus_rdata,
  input  logic [W-1:0]   pad_in,
  output logic [W-1:0]   pad_oe,
  output logic [W-1:0]   pad_do,
  output logic [W-1:0]   pad_pu
);
  logic [W-1:0] dir_q, dat_q, pu_q, od_q;
  logic [W-1:0] pad_sync, from_latch, pin_view;
  logic         expanded;

  assign expanded = is_expanded(op_mode);
  assign pin_view = (from_latch & dat_q) | (~from_latch & pad_sync);

  gpio_sync #(.W(W), .STAGES(SYNC_ST)) u_sync (
    .clk   (clk),
    .rst_n (rst_n),
    .d     (pad_in),
    .q     (pad_sync)
  );

  gpio_regbank #(.W(W), .AW(AW)) u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .hw_stby   (hw_stby),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .bus_rdata (bus_rdata),
    .pin_view  (pin_view),
    .dir_q     (dir_q),
    .dat_q     (dat_q),
    .pu_q      (pu_q),
    .od_q      (od_q)
  );

  gpio_pin_mux #(.W(W), .ENW(ENW)) u_pins (
    .clk        (clk),
    .rst_n      (rst_n),
    .expanded   (expanded),
    .addr_en    (addr_en),
    .addr_bus   (addr_bus),
    .hw_stby    (hw_stby),
    .sw_stby    (sw_stby),
    .stby_oe    (stby_oe),
    .dir_q      (dir_q),
    .dat_q      (dat_q),
    .pu_q       (pu_q),
    .od_q       (od_q),
    .pad_oe     (pad_oe),
    .pad_do     (pad_do),
    .pad_pu     (pad_pu),
    .from_latch (from_latch)
  );
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int W   = 8,
  parameter int ENW = 4
) (
  input logic           clk,
  input logic           rst_n,
  input logic [2:0]     op_mode,
  input logic [ENW-1:0] addr_en,
  input logic [W-1:0]   addr_bus,
  input logic           hw_stby,
  input logic           sw_stby,
  input logic           stby_oe,
  input logic           bus_sel,
  input logic [W-1:0]   bus_rdata,
  input logic [W-1:0]   pad_oe,
  input logic [W-1:0]   pad_do,
  input logic [W-1:0]   pad_pu
);
  logic         exp_m;
  logic [W-1:0] claim;

  assign exp_m = (op_mode == 3'd4) || (op_mode == 3'd5) || (op_mode == 3'd6);

  always_comb begin
    claim = '0;
    if (exp_m) begin
      for (int k = 0; k < W; k++) begin
        if (k < int'(addr_en)) claim[k] = 1'b1;
      end
    end
  end

  AST_HWSTBY_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    hw_stby |-> (pad_oe == '0) && (pad_pu == '0)); // R8

  AST_HW_EXIT_NO_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    ($fell(hw_stby) && !exp_m) |-> (pad_oe == '0)); // R8

  AST_PU_INPUT_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    (pad_pu & pad_oe) == '0); // R4

  AST_ADDR_DRIVE: assert property (@(posedge clk) disable iff (!rst_n)
    (!hw_stby && !sw_stby) |-> (((pad_oe & claim) == claim) &&
                                ((pad_do & claim) == (addr_bus & claim)))); // R6

  AST_SW_ADDR_FLOAT: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && !stby_oe && !hw_stby) |-> ((pad_oe & claim) == '0)); // R9

  AST_SW_ADDR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (sw_stby && $past(sw_stby) && stby_oe && !hw_stby && !$past(hw_stby) &&
     $stable(op_mode) && $stable(addr_en))
    |-> ((pad_do & claim) == ($past(pad_do) & claim))); // R9

  AST_IDLE_RDATA: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_sel |-> (bus_rdata == '0)); // R10
endmodule

bind gpio_port_ctrl gpio_port_chk #(.W(W), .ENW(ENW)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .op_mode   (op_mode),
  .addr_en   (addr_en),
  .addr_bus  (addr_bus),
  .hw_stby   (hw_stby),
  .sw_stby   (sw_stby),
  .stby_oe   (stby_oe),
  .bus_sel   (bus_sel),
  .bus_rdata (bus_rdata),
  .pad_oe    (pad_oe),
  .pad_do    (pad_do),
  .pad_pu    (pad_pu)
);

// File: tb/sim_gpio_port_ctrl.sv
module sim_gpio_port_ctrl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [2:0]  op_mode = 3'd7;
  logic [3:0]  addr_en = 4'd0;
  logic [7:0]  addr_bus = 8'h00;
  logic        hw_stby = 1'b0, sw_stby = 1'b0, stby_oe = 1'b0;
  logic        bus_sel = 1'b0, bus_wr = 1'b0;
  logic [15:0] bus_addr = 16'h0000;
  logic [7:0]  bus_wdata = 8'h00;
  logic [7:0]  bus_rdata;
  logic [7:0]  pad_in = 8'h00;
  logic [7:0]  pad_oe, pad_do, pad_pu;

  int total = 0;
  int bad = 0;
  logic [7:0] rv;

  always #2 clk = ~clk;

  gpio_port_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .op_mode(op_mode), .addr_en(addr_en),
    .addr_bus(addr_bus), .hw_stby(hw_stby), .sw_stby(sw_stby),
    .stby_oe(stby_oe), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .pad_in(pad_in), .pad_oe(pad_oe), .pad_do(pad_do), .pad_pu(pad_pu)
  );

  // {address, write data, expected read-back}
  localparam logic [31:0] VEC [8] = '{
    {16'hFF0A, 8'hA5, 8'hA5},
    {16'hFF41, 8'h3C, 8'h3C},
    {16'hFE48, 8'h81, 8'h81},
    {16'hFF0A, 8'h5A, 8'h5A},
    {16'hFF41, 8'h00, 8'h00},
    {16'hFE48, 8'h00, 8'h00},
    {16'hFF0B, 8'h77, 8'h00},
    {16'hFF09, 8'h11, 8'h00}
  };

  task automatic check(input string req, input logic [7:0] got, input logic [7:0] exp);
    total++;
    if (got !== exp) begin
      bad++;
      $display("FAIL %s: got %02h expected %02h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [15:0] a, input logic [7:0] d);
    @(negedge clk);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [15:0] a, output logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_sel = 1'b0;
  endtask

  initial begin
    #400000;
    bad++; total++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // R1 reset state
    rd(16'hFF0A, rv); check("R1 data", rv, 8'h00);
    rd(16'hFF41, rv); check("R1 pullup", rv, 8'h00);
    rd(16'hFE48, rv); check("R1 opendrain", rv, 8'h00);
    #1 check("R1 pad_oe", pad_oe, 8'h00);
    check("R1 pad_pu", pad_pu, 8'h00);
    check("R10 idle rdata", bus_rdata, 8'h00);

    // R2 / R10 table walk
    for (int i = 0; i < 8; i++) begin
      wr(VEC[i][31:16], VEC[i][15:8]);
      rd(VEC[i][31:16], rv);
      check((i < 6) ? "R2 readback" : "R10 unmapped read", rv, VEC[i][7:0]);
    end
    rd(16'hFF0A, rv); check("R10 R11 unmapped write kept data", rv, 8'h5A);

    // R3 R4 R11 single-chip outputs and inputs
    wr(16'hFE3A, 8'h0F);
    wr(16'hFF0A, 8'h05);
    wr(16'hFF41, 8'hF0);
    #1 check("R3 R11 pad_oe", pad_oe, 8'h0F);
    check("R3 pad_do", pad_do & 8'h0F, 8'h05);
    check("R4 pad_pu", pad_pu, 8'hF0);
    wr(16'hFF41, 8'hFF);
    #1 check("R4 no pullup on outputs", pad_pu, 8'hF0);

    // R5 open-drain
    wr(16'hFE48, 8'h03);
    #1 check("R5 pad_oe", pad_oe, 8'h0E);
    check("R5 pad_do", pad_do & 8'h0E, 8'h04);
    wr(16'hFE48, 8'h00);

    // R7 pin-state synchroniser latency
    @(negedge clk);
    pad_in = 8'hA0; bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = 16'hFFBA;
    @(negedge clk); #1 check("R7 one edge", bus_rdata, 8'h05);
    @(negedge clk); #1 check("R7 two edges", bus_rdata, 8'hA5);
    bus_sel = 1'b0;

    // R6 expanded mode address pins
    @(negedge clk);
    op_mode = 3'd5; addr_en = 4'd3; addr_bus = 8'h5A;
    #1 check("R6 pad_oe N=3", pad_oe, 8'h0F);
    check("R6 pad_do N=3", pad_do & 8'h0F, 8'h02);
    @(negedge clk);
    addr_en = 4'd12;
    #1 check("R6 pad_oe saturate", pad_oe, 8'hFF);
    check("R6 pad_do saturate", pad_do, 8'h5A);
    check("R6 R4 no pullup", pad_pu, 8'h00);
    @(negedge clk);
    op_mode = 3'd7; addr_en = 4'd8;
    #1 check("R6 single-chip ignores enable", pad_oe, 8'h0F);

    // R9 software standby
    @(negedge clk);
    op_mode = 3'd4; addr_en = 4'd4; addr_bus = 8'h3C; stby_oe = 1'b1;
    @(negedge clk);
    sw_stby = 1'b1;
    @(negedge clk);
    addr_bus = 8'hC3;
    #1 check("R9 hold oe", pad_oe, 8'h0F);
    check("R9 hold value", pad_do & 8'h0F, 8'h0C);
    @(negedge clk);
    stby_oe = 1'b0;
    #1 check("R9 float", pad_oe, 8'h00);
    @(negedge clk);
    sw_stby = 1'b0; op_mode = 3'd7; addr_en = 4'd0;
    #1 check("R9 direction kept", pad_oe, 8'h0F);

    // R8 hardware standby
    @(negedge clk);
    hw_stby = 1'b1;
    #1 check("R8 oe quiet", pad_oe, 8'h00);
    check("R8 pu quiet", pad_pu, 8'h00);
    wr(16'hFF0A, 8'hFF);
    @(negedge clk);
    hw_stby = 1'b0;
    #1 check("R8 direction cleared", pad_oe, 8'h00);
    check("R8 pullups as inputs", pad_pu, 8'hFF);
    rd(16'hFF0A, rv); check("R8 write ignored", rv, 8'h05);

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule